// File: doc/BRIEF.md
# NAND Hamming ECC Generator

This block computes a 22-bit Hamming parity code over one 256-byte NAND data block while the data streams past. Bytes arrive four at a time on a 32-bit beat bus qualified by a valid strobe. A start strobe opens a new block. Once the block's 64th beat has been taken, the block presents a 24-bit packed code and raises a one-cycle done strobe. The code is then held until the next block completes.

Internally it keeps one running XOR byte over the whole block. It also keeps one 8-bit accumulator for each pair of row parities, and that accumulator collects only the bytes whose index has the pair's select bit set. The other member of each pair is recovered at the end from the whole-block XOR. The column parities are also taken from that whole-block XOR byte. The two lowest row-parity pairs depend on the byte lane within a beat. All higher pairs depend only on the beat number, so each of them takes a whole beat at once or nothing.

The code is stored inverted, so an erased page (every byte 0xFF) gives an all-ones code. A controller that writes the code into the spare area can then leave erased pages untouched.

Top module: `nand_ecc_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `ecc_done` is 0 and `ecc_code` is all zeros.
- R2: A block is exactly 64 accepted beats. `ecc_done` is high for exactly one cycle: the cycle after the clock edge that accepts the 64th beat.
- R3: Byte lane j (bits 8j+7..8j) of the b-th accepted beat (b counted from 0) is byte index 4b+j of the block.
- R4: For k = 0..7, row parity rp(2k+1) is the XOR of all bits of the bytes whose index has bit k equal to 1. Row parity rp(2k) is the same XOR over the bytes whose index has bit k equal to 0.
- R5: With P the XOR of all 256 bytes, the column parities are: cp0 is the XOR of P bits {0,2,4,6}, cp1 of bits {1,3,5,7}, cp2 of bits {0,1,4,5}, cp3 of bits {2,3,6,7}, cp4 of bits 3..0, and cp5 of bits 7..4.
- R6: `ecc_code` bit i (i = 0..15) is the inverse of rp_i. Bits 17..16 are 1. Bit 18+i (i = 0..5) is the inverse of cp_i. An erased block of 256 bytes of 0xFF therefore gives 0xFFFFFF.
- R7: `blk_start` discards any partial block. If `beat_valid` is high in the same cycle, that beat becomes beat 0 of the new block. A `blk_start` without `beat_valid` only clears.
- R8: A cycle with `beat_valid` low contributes nothing, whatever `beat_data` holds, and does not advance the beat count.
- R9: After the 64th beat, valid beats are ignored and produce no done until the next `blk_start`.
- R10: `ecc_code` changes only in a cycle where `ecc_done` is high. It keeps its value through later starts and partial blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Opens a new block; clears accumulators and the beat count |
| beat_valid | input | 1 | Qualifies `beat_data` |
| beat_data | input | 32 | Four data bytes; lane 0 in bits 7..0 |
| ecc_done | output | 1 | One-cycle strobe when the code is ready |
| ecc_code | output | 24 | Packed inverted parity code |

## Verification
The hardest situations to reach are the boundaries of a block: a start that cuts into a half-filled block, valid beats that follow a finished block with no new start, and gaps of idle cycles carrying junk data in the middle of a block. The stimulus covers each of them with directed sequences. It also runs seeded random blocks with random gaps and with the start sent either on the first beat or on its own. Single nonzero bytes at the first and last index pin down the lane order and every parity bit against hand-computed codes. A byte-by-byte reference model in the bench checks every other block.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_HOLD = 1'b1
    } ecc_state_e;

    typedef struct packed {
        logic clear;
        logic accept;
        logic last;
    } beat_ctl_t;

    // Column parity set from the whole-block XOR byte.
    function automatic logic [5:0] col_parity(input logic [7:0] p);
        logic [5:0] c;
        c[0] = p[0] ^ p[2] ^ p[4] ^ p[6];
        c[1] = p[1] ^ p[3] ^ p[5] ^ p[7];
        c[2] = p[0] ^ p[1] ^ p[4] ^ p[5];
        c[3] = p[2] ^ p[3] ^ p[6] ^ p[7];
        c[4] = ^p[3:0];
        c[5] = ^p[7:4];
        return c;
    endfunction

endpackage

// File: rtl/ecc_beat_ctrl.sv
module ecc_beat_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int BEATS = 64,
    localparam int BW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          valid,
    output beat_ctl_t     ctl,
    output logic [BW-1:0] beat_idx
);

    ecc_state_e    state_q;
    logic [BW-1:0] cnt_q;
    logic          open_w;

    always_comb begin
        open_w     = start || (state_q == ST_FILL);
        beat_idx   = start ? '0 : cnt_q;
        ctl.clear  = start;
        ctl.accept = valid && open_w;
        ctl.last   = ctl.accept && (beat_idx == BW'(BEATS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else if (ctl.last) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else if (ctl.accept) begin
            state_q <= ST_FILL;
            cnt_q   <= beat_idx + BW'(1);
        end else if (start) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end
    end

endmodule

// File: rtl/ecc_row_accum.sv
module ecc_row_accum
    import nand_ecc_pkg::*;
#(
    parameter int PAIRS = 8,
    localparam int BW   = PAIRS - 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  beat_ctl_t                   ctl,
    input  logic [BW-1:0]               beat_idx,
    input  logic [WORD_W-1:0]           word,
    output logic [LANE_W-1:0]           par_d,
    output logic [PAIRS-1:0][LANE_W-1:0] odd_d
);

    logic [LANES-1:0][LANE_W-1:0] lane;
    logic [LANE_W-1:0]            beat_xor;
    logic [PAIRS-1:0][LANE_W-1:0] contrib;
    logic [LANE_W-1:0]            par_q;
    logic [PAIRS-1:0][LANE_W-1:0] odd_q;

    assign lane     = word;
    assign beat_xor = lane[0] ^ lane[1] ^ lane[2] ^ lane[3];

    // Only the odd member of each pair is accumulated.
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        if (k == 0) begin : g_lane_bit0
            assign contrib[k] = lane[1] ^ lane[3];
        end else if (k == 1) begin : g_lane_bit1
            assign contrib[k] = lane[2] ^ lane[3];
        end else begin : g_beat_bit
            assign contrib[k] = beat_idx[k-2] ? beat_xor : '0;
        end
    end

    always_comb begin
        par_d = ctl.clear ? '0 : par_q;
        odd_d = ctl.clear ? '0 : odd_q;
        if (ctl.accept) begin
            par_d = par_d ^ beat_xor;
            odd_d = odd_d ^ contrib;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= '0;
            odd_q <= '0;
        end else begin
            par_q <= par_d;
            odd_q <= odd_d;
        end
    end

endmodule

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
    import nand_ecc_pkg::*;
#(
    parameter int PAIRS   = 8,
    localparam int CODE_W = 2 * PAIRS + 8
) (
    input  logic [LANE_W-1:0]            par,
    input  logic [PAIRS-1:0][LANE_W-1:0] odd,
    output logic [CODE_W-1:0]            code
);

    logic [CODE_W-1:0] raw;
    logic              par_bit;

    assign par_bit = ^par;

    for (genvar k = 0; k < PAIRS; k++) begin : g_rp
        // Even member recovered from the whole-block parity.
        assign raw[2*k+1] = ^odd[k];
        assign raw[2*k]   = par_bit ^ (^odd[k]);
    end

    assign raw[2*PAIRS+1:2*PAIRS]        = 2'b00;
    assign raw[2*PAIRS+7:2*PAIRS+2]      = col_parity(par);
    assign code                          = ~raw;

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int BLOCK_BYTES = 256
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  blk_start,
    input  logic                                  beat_valid,
    input  logic [31:0]                           beat_data,
    output logic                                  ecc_done,
    output logic [2*$clog2(BLOCK_BYTES)+7:0]      ecc_code
);

    localparam int PAIRS  = $clog2(BLOCK_BYTES);
    localparam int BEATS  = BLOCK_BYTES / LANES;
    localparam int BW     = $clog2(BEATS);
    localparam int CODE_W = 2 * PAIRS + 8;

    beat_ctl_t                    ctl;
    logic [BW-1:0]                beat_idx;
    logic [LANE_W-1:0]            par_d;
    logic [PAIRS-1:0][LANE_W-1:0] odd_d;
    logic [CODE_W-1:0]            code_w;

    ecc_beat_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (blk_start),
        .valid    (beat_valid),
        .ctl      (ctl),
        .beat_idx (beat_idx)
    );

    ecc_row_accum #(.PAIRS(PAIRS)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .beat_idx (beat_idx),
        .word     (beat_data),
        .par_d    (par_d),
        .odd_d    (odd_d)
    );

    ecc_code_pack #(.PAIRS(PAIRS)) u_pack (
        .par  (par_d),
        .odd  (odd_d),
        .code (code_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ecc_done <= 1'b0;
            ecc_code <= '0;
        end else begin
            ecc_done <= ctl.last;
            if (ctl.last) begin
                ecc_code <= code_w;
            end
        end
    end

endmodule

// File: rtl/ecc_gen_chk.sv
module ecc_gen_chk #(
    parameter int BLOCK_BYTES = 256,
    localparam int BEATS      = BLOCK_BYTES / 4,
    localparam int BW         = $clog2(BEATS),
    localparam int CODE_W     = 2 * $clog2(BLOCK_BYTES) + 8
) (
    input logic              clk,
    input logic              rst,
    input logic              blk_start,
    input logic              beat_valid,
    input logic              ecc_done,
    input logic [CODE_W-1:0] ecc_code
);

    logic [BW:0] seen_q;
    logic [BW:0] seen_n;
    logic        open_q;

    always_comb begin
        seen_n = seen_q;
        if (blk_start) begin
            seen_n = beat_valid ? (BW+1)'(1) : '0;
        end else if (open_q && beat_valid) begin
            seen_n = seen_q + (BW+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            open_q <= 1'b1;
        end else begin
            seen_q <= seen_n;
            open_q <= (seen_n != (BW+1)'(BEATS));
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ecc_done && ecc_code == '0));

    // R2
    beat_count_chk: assert property (@(posedge clk) disable iff (rst)
        ecc_done |-> (seen_q == (BW+1)'(BEATS)));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ecc_done |=> !ecc_done);

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!open_q && !blk_start) |=> !ecc_done);

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ecc_done |-> $stable(ecc_code));

endmodule

bind nand_ecc_gen ecc_gen_chk #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .blk_start  (blk_start),
    .beat_valid (beat_valid),
    .ecc_done   (ecc_done),
    .ecc_code   (ecc_code)
);

// File: tb/test_nand_ecc_gen.sv
`timescale 1ns/1ps
module test_nand_ecc_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_start = 1'b0;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = '0;
    logic        ecc_done;
    logic [23:0] ecc_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] blk [256];
    logic [23:0] last_code;

    nand_ecc_gen i_nand_ecc_gen (
        .clk        (clk),
        .rst        (rst),
        .blk_start  (blk_start),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .ecc_done   (ecc_done),
        .ecc_code   (ecc_code)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Byte-by-byte model of R4, R5, R6.
    function automatic logic [23:0] ref_code();
        logic [7:0]  p = '0;
        logic [15:0] rp = '0;
        logic [5:0]  cp;
        for (int i = 0; i < 256; i++) begin
            p = p ^ blk[i];
            for (int k = 0; k < 8; k++) begin
                if (((i >> k) & 1) == 1) rp[2*k+1] = rp[2*k+1] ^ (^blk[i]);
                else                     rp[2*k]   = rp[2*k]   ^ (^blk[i]);
            end
        end
        cp[0] = ^(p & 8'h55);
        cp[1] = ^(p & 8'hAA);
        cp[2] = ^(p & 8'h33);
        cp[3] = ^(p & 8'hCC);
        cp[4] = ^(p & 8'h0F);
        cp[5] = ^(p & 8'hF0);
        return ~{cp, 2'b00, rp};
    endfunction

    function automatic logic [31:0] beat_word(input int b);
        return {blk[4*b+3], blk[4*b+2], blk[4*b+1], blk[4*b]};
    endfunction

    task automatic cyc(input logic s, input logic v, input logic [31:0] d);
        @(negedge clk);
        blk_start  = s;
        beat_valid = v;
        beat_data  = d;
    endtask

    // Sends the block in blk; ends at the negedge where done is visible.
    task automatic send_block(input bit sep_start, input int gap_pct);
        if (sep_start) cyc(1'b1, 1'b0, $urandom);
        for (int b = 0; b < 64; b++) begin
            while (int'($urandom % 100) < gap_pct) cyc(1'b0, 1'b0, $urandom);
            cyc((b == 0) && !sep_start, 1'b1, beat_word(b));
        end
        @(negedge clk);
        blk_start  = 1'b0;
        beat_valid = 1'b0;
        beat_data  = '0;
    endtask

    task automatic finish_block(input string req, input logic [23:0] exp);
        chk({req, " done"}, {31'd0, ecc_done}, 32'd1);
        chk({req, " code"}, {8'd0, ecc_code}, {8'd0, exp});
        last_code = ecc_code;
        @(negedge clk);
        chk("R2 done single cycle", {31'd0, ecc_done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        repeat (4) @(negedge clk);
        chk("R1 reset done", {31'd0, ecc_done}, 32'd0);
        chk("R1 reset code", {8'd0, ecc_code}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset code", {8'd0, ecc_code}, 32'd0);

        // R6: erased page
        foreach (blk[i]) blk[i] = 8'hFF;
        send_block(1'b0, 0);
        finish_block("R6 erased", 24'hFFFFFF);

        // R3 R4 R5: single byte at index 0 (lane 0 of beat 0)
        foreach (blk[i]) blk[i] = 8'h00;
        blk[0] = 8'h01;
        send_block(1'b0, 0);
        finish_block("R3 R4 R5 first byte", 24'hABAAAA);

        // R3 R4 R5: single byte at index 255 (lane 3 of beat 63)
        blk[0] = 8'h00;
        blk[255] = 8'h80;
        send_block(1'b1, 0);
        finish_block("R3 R4 R5 last byte", 24'h575555);

        // R3: single bytes at scattered lanes and beats
        for (int t = 0; t < 6; t++) begin
            foreach (blk[i]) blk[i] = 8'h00;
            blk[$urandom % 256] = 8'(1 << ($urandom % 8));
            send_block(1'b0, 10);
            finish_block("R3 single byte", ref_code());
        end

        // R8 R4 R5: random blocks with idle gaps carrying junk
        for (int t = 0; t < 16; t++) begin
            foreach (blk[i]) blk[i] = 8'($urandom);
            send_block(t[0], 30);
            finish_block("R8 random gaps", ref_code());
        end

        // R7 R10: abandoned partial block, then restart
        for (int b = 0; b < 20; b++) cyc(b == 0, 1'b1, $urandom);
        @(negedge clk);
        blk_start = 1'b0; beat_valid = 1'b0;
        chk("R10 code held mid-block", {8'd0, ecc_code}, {8'd0, last_code});
        chk("R7 no done on partial", {31'd0, ecc_done}, 32'd0);
        foreach (blk[i]) blk[i] = 8'($urandom);
        send_block(1'b0, 0);
        finish_block("R7 restart start+valid", ref_code());

        // R7: start alone mid-block, then beats without start
        for (int b = 0; b < 33; b++) cyc(b == 0, 1'b1, $urandom);
        foreach (blk[i]) blk[i] = 8'($urandom);
        send_block(1'b1, 5);
        finish_block("R7 restart start alone", ref_code());

        // R9: valid beats after a finished block are ignored
        for (int b = 0; b < 70; b++) begin
            cyc(1'b0, 1'b1, $urandom);
            chk("R9 no done after block", {31'd0, ecc_done}, 32'd0);
        end
        @(negedge clk);
        beat_valid = 1'b0;
        chk("R9 R10 code unchanged", {8'd0, ecc_code}, {8'd0, last_code});
        foreach (blk[i]) blk[i] = 8'($urandom);
        send_block(1'b0, 0);
        finish_block("R9 next block clean", ref_code());

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule